// File: doc/BRIEF.md
# Parity-width bus latch with preset and clear

This block holds a word for a wide address or data bus that may carry a parity bit. While the load control is high, the held word follows the data input. When the load control goes low, the word is frozen. Two active-low controls force the held word. One sets every bit to one, the other sets every bit to zero, and the set control wins when both are low. The output is a bus that several agents share. It is driven only when every bit of an active-low enable vector is low. A parameter chooses whether the bus shows the held word or its complement.

The design runs in one clock domain for FPGA fabric. All controls and data are sampled on the rising clock edge. The held word and the drive qualifier are registers, so every input reaches the outputs one cycle after the edge that samples it. The bus is presented as a value vector `q_val` plus a drive flag `q_drv`. A pad ring or a wrapper turns the pair into a three-state net, and `q_val` stays readable while the drive flag is low.

Top module: `busl_latch`

## Requirements
- R1: While `rst` is high at a rising edge, the held word becomes all zeros and `q_drv` becomes 0 after that edge. `rst` outranks every other control.
- R2: When `le` is 1 and neither force control is low, the held word takes the `d_in` sampled at that edge. `q_val` shows it one cycle later.
- R3: When `le` is 0 and neither force control is low, the held word and `q_val` stay unchanged.
- R4: When `mr_n` is 0 and `pre_n` is 1, the held word becomes all zeros after the edge, whatever `le` is.
- R5: When `pre_n` is 0, the held word becomes all ones after the edge, even if `mr_n` is also 0 or `le` is 1.
- R6: After a force control is released, the forced word is kept while `le` is 0. Once `le` is 1, the held word follows `d_in` again.
- R7: `q_drv` is 1 one cycle after an edge at which every bit of `oe_n` was 0, and 0 otherwise. One enable bit at 1 is enough to release the bus.
- R8: `oe_n` has no effect on the held word. Loads and holds work the same with the bus released, and the held word stays readable on `q_val`.
- R9: With `INVERT`=1, `q_val` is the bitwise complement of the held word. Clear then reads all ones, and preset reads all zeros.
- R10: With `HAS_PRE_MR`=0, `pre_n` and `mr_n` are ignored, and the latch only loads or holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| d_in | input | WIDTH | Data word to capture |
| le | input | 1 | Load control: 1 follows `d_in`, 0 holds |
| pre_n | input | 1 | Active-low force to all ones |
| mr_n | input | 1 | Active-low force to all zeros |
| oe_n | input | N_OE | Active-low output enables; all must be low to drive |
| q_val | output | WIDTH | Held word after optional inversion |
| q_drv | output | 1 | 1 when the bus is to be driven with `q_val` |

## Verification
The main function is exercised with an alternating word and its mirror. Loading one and then offering the other with `le` low separates a real hold from a latch that stays open. The enables are cleared one bit at a time, which shows the drive condition is an AND over every bit and not an OR or a single-bit test. A word loaded while the bus is released, read back later, shows that enables leave storage alone. Both force controls are tried together and then released with `le` low and then high, so priority and release behaviour are separated. Three instances run side by side on the same stimulus: true polarity, inverted polarity, and one with the force pins tied off.

// File: rtl/busl_pkg.sv
package busl_pkg;

  // Update selected for the held word at the next rising edge.
  typedef enum logic [2:0] {
    UPD_HOLD   = 3'd0,
    UPD_LOAD   = 3'd1,
    UPD_CLEAR  = 3'd2,
    UPD_PRESET = 3'd3,
    UPD_RESET  = 3'd4
  } upd_e;

endpackage

// File: rtl/busl_ctrl.sv
module busl_ctrl #(
  parameter bit HAS_PRE_MR = 1'b1
) (
  input  logic          rst,
  input  logic          le,
  input  logic          pre_n,
  input  logic          mr_n,
  output busl_pkg::upd_e upd
);
  import busl_pkg::*;

  logic pre_act;
  logic clr_act;

  generate
    if (HAS_PRE_MR) begin : g_force
      assign pre_act = ~pre_n;
      assign clr_act = ~mr_n;
    end else begin : g_noforce
      // force pins tied inactive
      assign pre_act = 1'b0;
      assign clr_act = 1'b0;
    end
  endgenerate

  // priority: reset, preset, clear, load, hold
  always_comb begin
    if (rst)          upd = UPD_RESET;
    else if (pre_act) upd = UPD_PRESET;
    else if (clr_act) upd = UPD_CLEAR;
    else if (le)      upd = UPD_LOAD;
    else              upd = UPD_HOLD;
  end

endmodule

// File: rtl/busl_store.sv
module busl_store #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  busl_pkg::upd_e   upd,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] word
);
  import busl_pkg::*;

  localparam logic [WIDTH-1:0] ALL_ONES  = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ALL_ZEROS = '0;

  always_ff @(posedge clk) begin
    case (upd)
      UPD_RESET:  word <= ALL_ZEROS;
      UPD_PRESET: word <= ALL_ONES;
      UPD_CLEAR:  word <= ALL_ZEROS;
      UPD_LOAD:   word <= d_in;
      default:    word <= word;
    endcase
  end

endmodule

// File: rtl/busl_oe_and.sv
module busl_oe_and #(
  parameter int N_OE = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_OE-1:0] oe_n,
  output logic            drv
);
  logic [N_OE:0] chain;

  assign chain[0] = 1'b1;
  generate
    for (genvar i = 0; i < N_OE; i++) begin : g_and
      assign chain[i+1] = chain[i] & ~oe_n[i];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) drv <= 1'b0;
    else     drv <= chain[N_OE];
  end

endmodule

// File: rtl/busl_latch.sv
module busl_latch #(
  parameter int WIDTH      = 8,
  parameter int N_OE       = 3,
  parameter bit HAS_PRE_MR = 1'b1,
  parameter bit INVERT     = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_in,
  input  logic             le,
  input  logic             pre_n,
  input  logic             mr_n,
  input  logic [N_OE-1:0]  oe_n,
  output logic [WIDTH-1:0] q_val,
  output logic             q_drv
);
  import busl_pkg::*;

  upd_e             upd;
  logic [WIDTH-1:0] word;

  busl_ctrl #(.HAS_PRE_MR(HAS_PRE_MR)) i_ctrl (
    .rst   (rst),
    .le    (le),
    .pre_n (pre_n),
    .mr_n  (mr_n),
    .upd   (upd)
  );

  busl_store #(.WIDTH(WIDTH)) i_store (
    .clk  (clk),
    .upd  (upd),
    .d_in (d_in),
    .word (word)
  );

  busl_oe_and #(.N_OE(N_OE)) i_oe (
    .clk  (clk),
    .rst  (rst),
    .oe_n (oe_n),
    .drv  (q_drv)
  );

  generate
    if (INVERT) begin : g_inv
      assign q_val = ~word;
    end else begin : g_true
      assign q_val = word;
    end
  endgenerate

endmodule

// File: rtl/busl_latch_chk.sv
module busl_latch_chk #(
  parameter int WIDTH      = 8,
  parameter int N_OE       = 3,
  parameter bit HAS_PRE_MR = 1'b1,
  parameter bit INVERT     = 1'b0
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] d_in,
  input logic             le,
  input logic             pre_n,
  input logic             mr_n,
  input logic [N_OE-1:0]  oe_n,
  input logic [WIDTH-1:0] q_val,
  input logic             q_drv
);
  localparam logic [WIDTH-1:0] POL  = INVERT ? {WIDTH{1'b1}} : '0;
  localparam logic [WIDTH-1:0] ONES = {WIDTH{1'b1}};

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (!q_drv && q_val == POL)); // R1

  AST_LOAD_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (le && pre_n && mr_n) |=> (q_val == ($past(d_in) ^ POL))); // R2

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!le && pre_n && mr_n) |=> $stable(q_val)); // R3

  AST_DRIVE_ALL_LOW: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (q_drv == ($past(oe_n) == '0))); // R7

  generate
    if (HAS_PRE_MR) begin : g_force_chk
      AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        (pre_n && !mr_n) |=> (q_val == POL)); // R4

      AST_PRESET_WINS: assert property (@(posedge clk) disable iff (rst)
        !pre_n |=> (q_val == (ONES ^ POL))); // R5
    end else begin : g_noforce_chk
      AST_FORCE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        !le |=> $stable(q_val)); // R10
    end
  endgenerate

endmodule

bind busl_latch busl_latch_chk #(
  .WIDTH(WIDTH), .N_OE(N_OE), .HAS_PRE_MR(HAS_PRE_MR), .INVERT(INVERT)
) i_chk (
  .clk(clk), .rst(rst), .d_in(d_in), .le(le), .pre_n(pre_n), .mr_n(mr_n),
  .oe_n(oe_n), .q_val(q_val), .q_drv(q_drv)
);

// File: tb/test_busl_latch.sv
`timescale 1ns/1ps
module test_busl_latch;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] d   = '0;
  logic       le  = 1'b0;
  logic       pre_n = 1'b1;
  logic       mr_n  = 1'b1;
  logic [2:0] oe_n  = 3'b111;

  logic [7:0] q_main;  logic drv_main;
  logic [8:0] q_inv;   logic drv_inv;
  logic [9:0] q_np;    logic drv_np;

  int n_chk = 0;
  int n_err = 0;

  // bench reference state
  logic [7:0] m_main = '0;
  logic [8:0] m_inv  = '0;
  logic [9:0] m_np   = '0;

  always #2.5 clk = ~clk;

  busl_latch #(.WIDTH(8), .N_OE(3), .HAS_PRE_MR(1'b1), .INVERT(1'b0)) i_busl_latch (
    .clk(clk), .rst(rst), .d_in(d[7:0]), .le(le), .pre_n(pre_n), .mr_n(mr_n),
    .oe_n(oe_n), .q_val(q_main), .q_drv(drv_main));

  busl_latch #(.WIDTH(9), .N_OE(1), .HAS_PRE_MR(1'b1), .INVERT(1'b1)) i_busl_latch_inv (
    .clk(clk), .rst(rst), .d_in(d[8:0]), .le(le), .pre_n(pre_n), .mr_n(mr_n),
    .oe_n(oe_n[0]), .q_val(q_inv), .q_drv(drv_inv));

  busl_latch #(.WIDTH(10), .N_OE(1), .HAS_PRE_MR(1'b0), .INVERT(1'b0)) i_busl_latch_np (
    .clk(clk), .rst(rst), .d_in(d), .le(le), .pre_n(pre_n), .mr_n(mr_n),
    .oe_n(oe_n[0]), .q_val(q_np), .q_drv(drv_np));

  // row: le pre_n mr_n oe_n[2:0] d[9:0] exp_q[7:0] exp_drv req[3:0]
  localparam int NROW = 14;
  localparam logic [28:0] TBL [NROW] = '{
    {1'b1,1'b1,1'b1,3'b000,10'h0A5,8'hA5,1'b1,4'd2},  // R2 load
    {1'b0,1'b1,1'b1,3'b000,10'h05A,8'hA5,1'b1,4'd3},  // R3 hold
    {1'b0,1'b1,1'b1,3'b001,10'h3FF,8'hA5,1'b0,4'd7},  // R7 bit0 high
    {1'b0,1'b1,1'b1,3'b010,10'h3FF,8'hA5,1'b0,4'd7},  // R7 bit1 high
    {1'b0,1'b1,1'b1,3'b100,10'h3FF,8'hA5,1'b0,4'd7},  // R7 bit2 high
    {1'b1,1'b1,1'b1,3'b111,10'h03C,8'h3C,1'b0,4'd8},  // R8 load while released
    {1'b0,1'b1,1'b0,3'b000,10'h0FF,8'h00,1'b1,4'd4},  // R4 clear
    {1'b0,1'b1,1'b1,3'b000,10'h0FF,8'h00,1'b1,4'd6},  // R6 keep cleared
    {1'b0,1'b0,1'b0,3'b000,10'h011,8'hFF,1'b1,4'd5},  // R5 preset beats clear
    {1'b0,1'b1,1'b1,3'b000,10'h011,8'hFF,1'b1,4'd6},  // R6 keep preset
    {1'b1,1'b0,1'b1,3'b000,10'h022,8'hFF,1'b1,4'd5},  // R5 preset beats load
    {1'b1,1'b1,1'b1,3'b000,10'h022,8'h22,1'b1,4'd6},  // R6 follows again
    {1'b1,1'b1,1'b1,3'b000,10'h0C3,8'hC3,1'b1,4'd2},  // R2 tracks
    {1'b0,1'b1,1'b1,3'b000,10'h000,8'hC3,1'b1,4'd3}   // R3 freeze
  };

  task automatic chk(input string req, input string what, input logic [9:0] act,
                     input logic [9:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // drive at the falling edge, update the reference, sample at the next falling edge
  task automatic step(input logic r, input logic l, input logic p, input logic m,
                      input logic [2:0] o, input logic [9:0] dv);
    rst = r; le = l; pre_n = p; mr_n = m; oe_n = o; d = dv;
    if (r)       begin m_main = '0;       m_inv = '0;       end
    else if (!p) begin m_main = '1;       m_inv = '1;       end
    else if (!m) begin m_main = '0;       m_inv = '0;       end
    else if (l)  begin m_main = dv[7:0];  m_inv = dv[8:0];  end
    if (r)       m_np = '0;
    else if (l)  m_np = dv;                                 // R10 force pins ignored
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_side(input logic r, input logic [2:0] o);
    chk("R9", "inverted q", {1'b0, q_inv}, {1'b0, ~m_inv});
    chk("R7", "inverted drv", {9'd0, drv_inv}, {9'd0, !r && !o[0]});
    chk("R10", "no-force q", q_np, m_np);
    chk("R7", "no-force drv", {9'd0, drv_np}, {9'd0, !r && !o[0]});
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : main
    @(negedge clk);
    step(1'b1, 1'b1, 1'b1, 1'b1, 3'b000, 10'h155);
    step(1'b1, 1'b1, 1'b0, 1'b1, 3'b000, 10'h155);
    // R1 reset state, reset outranks load and preset
    chk("R1", "main q", {2'b0, q_main}, 10'h000);
    chk("R1", "main drv", {9'd0, drv_main}, 10'd0);
    chk("R1", "inverted q", {1'b0, q_inv}, 10'h1FF);
    chk("R1", "no-force drv", {9'd0, drv_np}, 10'd0);

    for (int i = 0; i < NROW; i++) begin
      logic [28:0] row;
      string tag;
      row = TBL[i];
      tag = $sformatf("R%0d row %0d", row[3:0], i);
      step(1'b0, row[28], row[27], row[26], row[25:23], row[22:13]);
      chk(tag, "main q", {2'b0, q_main}, {2'b0, row[12:5]});
      chk(tag, "main drv", {9'd0, drv_main}, {9'd0, row[4]});
      chk(tag, "main model", {2'b0, q_main}, {2'b0, m_main});
      chk_side(1'b0, row[25:23]);
    end

    // R8 word loaded while released is still held and readable after re-enable
    step(1'b0, 1'b1, 1'b1, 1'b1, 3'b111, 10'h2E7);
    step(1'b0, 1'b0, 1'b1, 1'b1, 3'b000, 10'h000);
    chk("R8", "held after re-enable", {2'b0, q_main}, 10'h0E7);
    chk("R8", "drive after re-enable", {9'd0, drv_main}, 10'd1);
    chk_side(1'b0, 3'b000);

    // R9 clear and preset seen through inversion
    step(1'b0, 1'b1, 1'b1, 1'b0, 3'b000, 10'h3FF);
    chk("R9", "clear inverted", {1'b0, q_inv}, 10'h1FF);
    step(1'b0, 1'b0, 1'b0, 1'b1, 3'b000, 10'h000);
    chk("R9", "preset inverted", {1'b0, q_inv}, 10'h000);
    // R10 preset low with le high: no-force instance loads the data
    step(1'b0, 1'b1, 1'b0, 1'b0, 3'b000, 10'h2A9);
    chk("R10", "no-force loads under force", q_np, 10'h2A9);
    chk("R5", "main preset under le", {2'b0, q_main}, 10'h0FF);

    // R1 reset mid-run
    step(1'b1, 1'b1, 1'b1, 1'b1, 3'b000, 10'h1C7);
    chk("R1", "main q after mid reset", {2'b0, q_main}, 10'h000);
    chk("R1", "main drv after mid reset", {9'd0, drv_main}, 10'd0);
    chk_side(1'b1, 3'b000);

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule